// File: doc/BRIEF.md
# Chip-Select Interleave Configuration Engine

This sequencer sits beside the chip-select register bank of a memory controller. After the bank has been loaded with per-rank base values, shared size masks and bank-geometry codes, a start strobe makes it decide whether the populated ranks can be interleaved on low-order address bits. If they can, it rewrites the address-map registers so that the chip-select selection bits trade places with a group of low address bits. Consecutive accesses then spread across ranks instead of filling one rank first.

The engine talks to the register bank through a single synchronous port that makes one access per clock. It first scans the bank to check compatibility. It then derives two swap masks from a bank-geometry lookup and the common rank size. It finishes with a read-modify-write pass over the affected registers. A one-cycle done pulse marks the end of every run. When interleaving is requested but the population does not allow it, a sticky error flag is raised and no register is changed.

Top module: `csi_engine`

## Requirements
- R1: After reset, `done`, `intlvDisErr`, `regRdEn` and `regWrEn` are all low.
- R2: Register port map: addresses 0 to 7 hold the rank base registers, 8 to 11 the shared mask registers (rank n uses 8 + n/2), and 12 the bank-geometry register. The port makes at most one access per clock, and read data arrives the cycle after `regRdEn`. A start with `intlvReq` low ends in a done pulse with no write and the error flag low.
- R3: A rank is populated when bit 0 of its base register is set. Its size is mask bits 28:19 plus one. Its geometry code is the 4-bit field of the bank-geometry register at bit offset 4*(n/2). Every populated rank must match the first populated rank in both size and code. Any mismatch sets `intlvDisErr` and causes no write.
- R4: Interleaving also needs the populated count to be exactly 2, 4 or 8. Any other count (0, 1, 3, ...) sets `intlvDisErr` and causes no write.
- R5: A geometry code of 12 or above counts as incompatible and sets `intlvDisErr`.
- R6: The low swap position comes from the geometry code: codes 0..11 map to 6,7,7,8,8,8,8,8,9,9,8,9. One is added when `wideMode` is high.
- R7: With k = count-1: lowMask = k << lowPos, highMask = k << (lowest set bit of size + 19), and delta = lsb(highMask) - lsb(lowMask). Each rewritten register keeps the bits outside both masks, moves the lowMask bits up by delta, and moves the highMask bits down by delta.
- R8: A base register is rewritten when either of its bits 1:0 is set, populated or not. A mask register is rewritten only after the base of the even rank of its pair was rewritten, so it changes at most once.
- R9: `done` is high for exactly one cycle per accepted start. A start during a run is ignored.
- R10: `intlvDisErr` stays high after the run until the next start is accepted, and is then cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| intlvReq | input | 1 | Interleaving is requested for this run |
| wideMode | input | 1 | 128-bit data path: low swap position plus one |
| regAddr | output | 4 | Register port address |
| regRdEn | output | 1 | Read strobe |
| regRdData | input | 32 | Read data, valid the cycle after regRdEn |
| regWrEn | output | 1 | Write strobe |
| regWrData | output | 32 | Write data |
| done | output | 1 | One-cycle end-of-run pulse |
| intlvDisErr | output | 1 | Interleave requested but not possible |

## Verification
The assertions assume that the register bank answers a read one cycle later and is not written by anyone else during a run, so that a write back to the same address always follows its own read by two cycles. They also assume reset is held for at least one clock before the first start. The bench models the register bank as a plain array with exactly that read latency. It loads the array only while the engine is idle, and it drives start and the mode inputs on falling edges, so the bank contents seen by a run never change underneath it.

// File: rtl/csi_pkg.sv
package csi_pkg;
  localparam int CS_NUM   = 8;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 4;
  localparam int MASK_LSB = 19;
  localparam int MASK_W   = 10;
  localparam int ENC_W    = 4;
  localparam int ENC_MAX  = 12;

  localparam int CS_IDX_W  = $clog2(CS_NUM);
  localparam int SIZE_W    = MASK_W + 1;
  localparam int CNT_W     = $clog2(CS_NUM + 1);
  localparam int SHIFT_W   = $clog2(REG_W);
  localparam int MASK_BASE = CS_NUM;
  localparam int BANK_ADDR = CS_NUM + CS_NUM / 2;

  typedef struct packed {
    logic clr;      // new run: forget scan results
    logic capBank;  // latch bank-geometry register
    logic capData;  // latch read data for rewrite
    logic chkMask;  // evaluate one populated rank
    logic calc;     // latch swap masks and delta
  } csi_strobe_t;
endpackage

// File: rtl/csi_datapath.sv
module csi_datapath
  import csi_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  csi_strobe_t         stb,
  input  logic [CS_IDX_W-1:0] csIdx,
  input  logic                wideMode,
  input  logic [REG_W-1:0]    rdData,
  output logic                baseEnNow,
  output logic                baseTouchNow,
  output logic                mismatchNow,
  output logic                countOk,
  output logic [REG_W-1:0]    swapData
);
  logic [REG_W-1:0]   bankReg, curData, loMask, hiMask;
  logic [SIZE_W-1:0]  refSize, sizeNow;
  logic [ENC_W-1:0]   refEnc, encNow;
  logic [CNT_W-1:0]   enCount;
  logic [SHIFT_W-1:0] delta;
  logic [SHIFT_W:0]   lowPos, hiPos;
  logic [REG_W-1:0]   span, loNext, hiNext;

  function automatic logic [SHIFT_W:0] lowPosOf(input logic [ENC_W-1:0] enc);
    case (enc)
      4'd0:                      lowPosOf = 6;
      4'd1, 4'd2:                lowPosOf = 7;
      4'd8, 4'd9, 4'd11:         lowPosOf = 9;
      default:                   lowPosOf = 8;
    endcase
  endfunction

  function automatic logic [SHIFT_W-1:0] lsbIdx(input logic [REG_W-1:0] v);
    logic [SHIFT_W-1:0] r;
    r = '0;
    for (int i = REG_W - 1; i >= 0; i--)
      if (v[i]) r = SHIFT_W'(i);
    return r;
  endfunction

  assign baseEnNow    = rdData[0];
  assign baseTouchNow = |rdData[1:0];
  assign sizeNow      = SIZE_W'(rdData[MASK_LSB +: MASK_W]) + SIZE_W'(1);
  assign encNow       = bankReg[(int'(csIdx) / 2) * ENC_W +: ENC_W];

  always_comb begin
    mismatchNow = (int'(encNow) >= ENC_MAX);
    if (enCount != '0 && (sizeNow != refSize || encNow != refEnc))
      mismatchNow = 1'b1;
  end

  assign countOk = (enCount == CNT_W'(2)) || (enCount == CNT_W'(4)) ||
                   (enCount == CNT_W'(8));

  assign lowPos = lowPosOf(refEnc) + (SHIFT_W + 1)'(wideMode);
  assign hiPos  = (SHIFT_W + 1)'(lsbIdx(REG_W'(refSize))) + (SHIFT_W + 1)'(MASK_LSB);
  assign span   = REG_W'(enCount - CNT_W'(1));
  assign loNext = span << lowPos;
  assign hiNext = span << hiPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankReg <= '0;
      curData <= '0;
      loMask  <= '0;
      hiMask  <= '0;
      refSize <= '0;
      refEnc  <= '0;
      enCount <= '0;
      delta   <= '0;
    end else begin
      if (stb.clr) enCount <= '0;
      if (stb.capBank) bankReg <= rdData;
      if (stb.capData) curData <= rdData;
      if (stb.chkMask && !mismatchNow) begin
        if (enCount == '0) begin
          refSize <= sizeNow;
          refEnc  <= encNow;
        end
        enCount <= enCount + CNT_W'(1);
      end
      if (stb.calc) begin
        loMask <= loNext;
        hiMask <= hiNext;
        delta  <= lsbIdx(hiNext) - lsbIdx(loNext);
      end
    end
  end

  assign swapData = (curData & ~loMask & ~hiMask) |
                    ((curData & loMask) << delta) |
                    ((curData & hiMask) >> delta);
endmodule

// File: rtl/csi_control.sv
module csi_control
  import csi_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                intlvReq,
  input  logic                baseEnNow,
  input  logic                baseTouchNow,
  input  logic                mismatchNow,
  input  logic                countOk,
  output csi_strobe_t         stb,
  output logic [CS_IDX_W-1:0] csIdx,
  output logic [ADDR_W-1:0]   regAddr,
  output logic                regRdEn,
  output logic                regWrEn,
  output logic                done,
  output logic                intlvDisErr
);
  typedef enum logic [3:0] {
    S_IDLE, S_RD_BANK, S_GET_BANK, S_RD_BASE, S_GET_BASE, S_RD_MASK,
    S_GET_MASK, S_CALC, S_RW_RDB, S_RW_GETB, S_RW_WRB, S_RW_RDM,
    S_RW_GETM, S_RW_WRM, S_FINISH
  } state_t;

  state_t state;
  logic   lastCs;
  logic [ADDR_W-1:0] baseAddr, maskAddr;

  assign lastCs   = (int'(csIdx) == CS_NUM - 1);
  assign baseAddr = ADDR_W'(csIdx);
  assign maskAddr = ADDR_W'(MASK_BASE) + ADDR_W'(csIdx >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      csIdx       <= '0;
      intlvDisErr <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          intlvDisErr <= 1'b0;
          csIdx       <= '0;
          state       <= intlvReq ? S_RD_BANK : S_FINISH;
        end
        S_RD_BANK:  state <= S_GET_BANK;
        S_GET_BANK: state <= S_RD_BASE;
        S_RD_BASE:  state <= S_GET_BASE;
        S_GET_BASE: begin
          if (baseEnNow)   state <= S_RD_MASK;
          else if (lastCs) state <= S_CALC;
          else begin
            csIdx <= csIdx + 1'b1;
            state <= S_RD_BASE;
          end
        end
        S_RD_MASK:  state <= S_GET_MASK;
        S_GET_MASK: begin
          if (mismatchNow) begin
            intlvDisErr <= 1'b1;
            state       <= S_FINISH;
          end else if (lastCs) state <= S_CALC;
          else begin
            csIdx <= csIdx + 1'b1;
            state <= S_RD_BASE;
          end
        end
        S_CALC: begin
          csIdx <= '0;
          if (countOk) state <= S_RW_RDB;
          else begin
            intlvDisErr <= 1'b1;
            state       <= S_FINISH;
          end
        end
        S_RW_RDB:  state <= S_RW_GETB;
        S_RW_GETB: begin
          if (baseTouchNow) state <= S_RW_WRB;
          else if (lastCs)  state <= S_FINISH;
          else begin
            csIdx <= csIdx + 1'b1;
            state <= S_RW_RDB;
          end
        end
        S_RW_WRB: begin
          if (!csIdx[0])   state <= S_RW_RDM;
          else if (lastCs) state <= S_FINISH;
          else begin
            csIdx <= csIdx + 1'b1;
            state <= S_RW_RDB;
          end
        end
        S_RW_RDM:  state <= S_RW_GETM;
        S_RW_GETM: state <= S_RW_WRM;
        S_RW_WRM: begin
          csIdx <= csIdx + 1'b1;
          state <= S_RW_RDB;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb     = '0;
    regRdEn = 1'b0;
    regWrEn = 1'b0;
    regAddr = baseAddr;
    case (state)
      S_IDLE:     stb.clr = start;
      S_RD_BANK:  begin regRdEn = 1'b1; regAddr = ADDR_W'(BANK_ADDR); end
      S_GET_BANK: stb.capBank = 1'b1;
      S_RD_BASE:  regRdEn = 1'b1;
      S_RD_MASK:  begin regRdEn = 1'b1; regAddr = maskAddr; end
      S_GET_MASK: stb.chkMask = 1'b1;
      S_CALC:     stb.calc = 1'b1;
      S_RW_RDB:   regRdEn = 1'b1;
      S_RW_GETB:  stb.capData = 1'b1;
      S_RW_WRB:   regWrEn = 1'b1;
      S_RW_RDM:   begin regRdEn = 1'b1; regAddr = maskAddr; end
      S_RW_GETM:  begin stb.capData = 1'b1; regAddr = maskAddr; end
      S_RW_WRM:   begin regWrEn = 1'b1; regAddr = maskAddr; end
      default:    ;
    endcase
  end

  assign done = (state == S_FINISH);
endmodule

// File: rtl/csi_engine.sv
module csi_engine
  import csi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              intlvReq,
  input  logic              wideMode,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regRdEn,
  input  logic [REG_W-1:0]  regRdData,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrData,
  output logic              done,
  output logic              intlvDisErr
);
  csi_strobe_t         stb;
  logic [CS_IDX_W-1:0] csIdx;
  logic baseEnNow, baseTouchNow, mismatchNow, countOk;

  csi_control u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .intlvReq(intlvReq),
    .baseEnNow(baseEnNow), .baseTouchNow(baseTouchNow),
    .mismatchNow(mismatchNow), .countOk(countOk), .stb(stb),
    .csIdx(csIdx), .regAddr(regAddr), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .done(done), .intlvDisErr(intlvDisErr)
  );

  csi_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .csIdx(csIdx), .wideMode(wideMode),
    .rdData(regRdData), .baseEnNow(baseEnNow), .baseTouchNow(baseTouchNow),
    .mismatchNow(mismatchNow), .countOk(countOk), .swapData(regWrData)
  );
endmodule

// File: rtl/csi_checker.sv
module csi_checker
  import csi_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regRdEn,
  input logic              regWrEn,
  input logic              done,
  input logic              intlvDisErr
);
  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(regRdEn && regWrEn)); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn || regWrEn) |-> (int'(regAddr) <= BANK_ADDR)); // R2
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> ($past(regRdEn, 2) && $past(regAddr, 2) == regAddr)); // R7
  AST_NO_BANK_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (int'(regAddr) != BANK_ADDR)); // R8
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    intlvDisErr |-> !regWrEn); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!regRdEn && !regWrEn)); // R9
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intlvDisErr) |-> $past(!regRdEn && !regWrEn)); // R10
endmodule

bind csi_engine csi_checker u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdEn(regRdEn),
  .regWrEn(regWrEn), .done(done), .intlvDisErr(intlvDisErr)
);

// File: tb/sim_csi_engine.sv
module sim_csi_engine;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, intlvReq = 1'b0, wideMode = 1'b0;
  logic [3:0]  regAddr;
  logic        regRdEn, regWrEn, done, intlvDisErr;
  logic [31:0] regRdData, regWrData;
  logic [31:0] rf [13];
  logic [31:0] expRf [13];
  int checks = 0, fails = 0, wrCount = 0, doneCount = 0, cyc = 0;

  always #5 clk = ~clk;

  csi_engine u0 (
    .clk(clk), .rstN(rstN), .start(start), .intlvReq(intlvReq),
    .wideMode(wideMode), .regAddr(regAddr), .regRdEn(regRdEn),
    .regRdData(regRdData), .regWrEn(regWrEn), .regWrData(regWrData),
    .done(done), .intlvDisErr(intlvDisErr)
  );

  // register bank model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (regWrEn) begin rf[regAddr] <= regWrData; wrCount <= wrCount + 1; end
    if (regRdEn) regRdData <= rf[regAddr];
    if (done) doneCount <= doneCount + 1;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    fails = fails + 1;
    $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // entry: {ranks populated[8], size field[10], code[4], wide, req, expected error}
  localparam logic [24:0] VEC [10] = '{
    {8'h03, 10'h007, 4'd0,  1'b0, 1'b1, 1'b0},
    {8'h0F, 10'h00F, 4'd5,  1'b1, 1'b1, 1'b0},
    {8'hFF, 10'h003, 4'd10, 1'b0, 1'b1, 1'b0},
    {8'h0A, 10'h01F, 4'd11, 1'b0, 1'b1, 1'b0},
    {8'h07, 10'h007, 4'd0,  1'b0, 1'b1, 1'b1},
    {8'h01, 10'h007, 4'd0,  1'b0, 1'b1, 1'b1},
    {8'h00, 10'h007, 4'd0,  1'b0, 1'b1, 1'b1},
    {8'h03, 10'h007, 4'd0,  1'b0, 1'b0, 1'b0},
    {8'h03, 10'h007, 4'd12, 1'b0, 1'b1, 1'b1},
    {8'h05, 10'h3FF, 4'd9,  1'b1, 1'b1, 1'b0}
  };

  function automatic string tagOf(input int row);
    case (row)
      0: return "R7"; 1, 2, 9: return "R6"; 3: return "R8";
      4, 5, 6: return "R4"; 7: return "R2"; default: return "R5";
    endcase
  endfunction

  function automatic int lowTab(input int code);
    case (code)
      0: return 6; 1, 2: return 7; 8, 9, 11: return 9; default: return 8;
    endcase
  endfunction

  // requirement-level model over the expected register image
  function automatic logic model(input logic req, input logic wide);
    int cnt = 0, sz0 = 0, code0 = 0, lowP, hiP, d, szLsb;
    logic abort = 1'b0;
    logic [31:0] lo, hi, v;
    for (int cs = 0; cs < 8; cs++) begin
      if (!abort && expRf[cs][0]) begin
        int sz = int'(expRf[8 + cs / 2][28:19]) + 1;
        int code = int'((expRf[12] >> (4 * (cs / 2))) & 32'hF);
        if (code >= 12 || (cnt > 0 && (sz != sz0 || code != code0))) abort = 1'b1;
        else begin
          if (cnt == 0) begin sz0 = sz; code0 = code; end
          cnt++;
        end
      end
    end
    if (!req) return 1'b0;
    if (abort || !(cnt == 2 || cnt == 4 || cnt == 8)) return 1'b1;
    lowP = lowTab(code0) + int'(wide);
    szLsb = 0;
    for (int b = 10; b >= 0; b--) if (sz0[b]) szLsb = b;
    hiP = szLsb + 19;
    d = hiP - lowP;
    lo = 32'(cnt - 1) << lowP;
    hi = 32'(cnt - 1) << hiP;
    for (int cs = 0; cs < 8; cs++) begin
      if (expRf[cs][1:0] != 2'b00) begin
        v = expRf[cs];
        expRf[cs] = (v & ~lo & ~hi) | ((v & lo) << d) | ((v & hi) >> d);
        if (cs % 2 == 0) begin
          v = expRf[8 + cs / 2];
          expRf[8 + cs / 2] = (v & ~lo & ~hi) | ((v & lo) << d) | ((v & hi) >> d);
        end
      end
    end
    return 1'b0;
  endfunction

  task automatic runEngine(input logic req, input logic wide, input string tag);
    int w0 = wrCount, d0 = doneCount, n = 0;
    @(negedge clk);
    start = 1'b1; intlvReq = req; wideMode = wide;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 400) begin @(negedge clk); n++; end
    chk({tag, " done seen"}, 32'(done), 32'd1);
    @(negedge clk);
    chk({tag, " R9 done width"}, 32'(done), 32'd0);
    chk({tag, " R9 done count"}, 32'(doneCount - d0), 32'd1);
    if (!req) chk({tag, " R2 no writes"}, 32'(wrCount - w0), 32'd0);
  endtask

  task automatic loadVec(input logic [24:0] e);
    for (int i = 0; i < 8; i++)
      rf[i] = 32'(e[17 + i]) | (32'(i) << 22) | (32'(i) << 6) |
              ((i == 6 && !e[23]) ? 32'h2 : 32'h0);
    for (int p = 0; p < 4; p++) rf[8 + p] = (32'(e[16:7]) << 19) | 32'h3E0 | (32'(p) << 12);
    rf[12] = {16'h0, {4{e[6:3]}}};
  endtask

  task automatic compareAll(input string tag);
    for (int i = 0; i < 13; i++) chk($sformatf("%s reg%0d", tag, i), rf[i], expRf[i]);
  endtask

  initial begin
    logic expErr;
    int d0;
    for (int i = 0; i < 13; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1 done at reset", 32'(done), 32'd0);
    chk("R1 err at reset", 32'(intlvDisErr), 32'd0);
    chk("R1 access at reset", 32'(regRdEn | regWrEn), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'({done, intlvDisErr, regRdEn, regWrEn}), 32'd0);

    for (int r = 0; r < 10; r++) begin
      loadVec(VEC[r]);
      for (int i = 0; i < 13; i++) expRf[i] = rf[i];
      expErr = model(VEC[r][1], VEC[r][2]);
      chk({tagOf(r), " model err vs table"}, 32'(expErr), 32'(VEC[r][0]));
      runEngine(VEC[r][1], VEC[r][2], tagOf(r));
      chk({tagOf(r), " error flag"}, 32'(intlvDisErr), 32'(VEC[r][0]));
      compareAll(tagOf(r));
    end

    // R7 hand-computed: ranks 0,1, size 8, code 0 -> swap bit 6 with bit 22
    for (int i = 0; i < 13; i++) rf[i] = '0;
    rf[0] = 32'h0000_0001; rf[1] = 32'h0040_0001; rf[8] = 32'h0038_03E0;
    runEngine(1'b1, 1'b0, "R7 hand");
    chk("R7 base1", rf[1], 32'h0000_0041);
    chk("R7 mask0", rf[8], 32'h0078_03A0);
    chk("R7 base0 kept", rf[0], 32'h0000_0001);
    // R6 wide: swap bit 7 with bit 22
    rf[0] = 32'h0000_0001; rf[1] = 32'h0040_0001; rf[8] = 32'h0038_03E0;
    runEngine(1'b1, 1'b1, "R6 wide");
    chk("R6 wide base1", rf[1], 32'h0000_0081);
    chk("R6 wide mask0", rf[8], 32'h0078_0360);

    // R3 size mismatch between pairs
    for (int i = 0; i < 13; i++) rf[i] = '0;
    for (int i = 0; i < 4; i++) rf[i] = 32'h1 | (32'(i) << 22);
    rf[8] = 32'h0038_0000; rf[9] = 32'h0078_0000;
    for (int i = 0; i < 13; i++) expRf[i] = rf[i];
    runEngine(1'b1, 1'b0, "R3 size");
    chk("R3 size mismatch err", 32'(intlvDisErr), 32'd1);
    compareAll("R3 size");
    // R3 code mismatch between pairs
    rf[9] = 32'h0038_0000; rf[12] = 32'h0000_0010;
    for (int i = 0; i < 13; i++) expRf[i] = rf[i];
    runEngine(1'b1, 1'b0, "R3 code");
    chk("R3 code mismatch err", 32'(intlvDisErr), 32'd1);
    compareAll("R3 code");

    // R10 flag held while idle, cleared by next accepted start
    repeat (5) @(negedge clk);
    chk("R10 err held", 32'(intlvDisErr), 32'd1);
    runEngine(1'b0, 1'b0, "R10 clear");
    chk("R10 err cleared", 32'(intlvDisErr), 32'd0);

    // R9 start during a run is ignored
    loadVec(VEC[2]);
    for (int i = 0; i < 13; i++) expRf[i] = rf[i];
    expErr = model(1'b1, 1'b0);
    d0 = doneCount;
    @(negedge clk); start = 1'b1; intlvReq = 1'b1; wideMode = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    start = 1'b1; intlvReq = 1'b0;
    @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    chk("R9 one done despite extra start", 32'(doneCount - d0), 32'd1);
    chk("R9 err after ignored start", 32'(intlvDisErr), 32'(expErr));
    compareAll("R9 busy");
    summary();
  end
endmodule